// File: doc/BRIEF.md
# I2C register-access slave

This block is the serial front end of a device register map on a two-wire bus. A system clock oversamples SCL and SDA, and each line passes through a two-flop synchronizer. The block finds start and stop conditions on the synchronized lines. It then compares the first byte against its 7-bit device address. Five fixed high bits form that address, and two strap inputs supply the low two bits. When the address matches, the block acknowledges it. A write then carries a two-byte register subaddress followed by any number of data bytes. A read returns bytes to the master until the master answers with a NACK.

The register storage and its address autoincrement are in a separate register engine. The block reaches that engine through a byte interface with these parts:

- a strobe that loads a subaddress;
- a write strobe with a data byte;
- a read strobe, answered by a byte on the following clock.

A stop condition ends the transfer and the burst. A repeated start runs the address phase again and does not load a new subaddress. A write that sets the subaddress can therefore be followed at once by a read from that location.

The open-drain SDA line is split into a sampled input and an output enable that pulls the line low.

Top module: `i2c_regport_slave`

## Requirements
- R1: A stop condition (SDA rising while SCL is high) releases SDA within one clock and pulses `xfer_end_o` for one clock; no strobe follows until a new start.
- R2: After a start condition (SDA falling while SCL is high), the first eight bits are taken MSB first as address `{5'b01110, strap_a1_i, strap_a0_i}` followed by R/W (1 = read, 0 = write); on a match SDA is pulled low for the whole ninth clock.
- R3: On an address mismatch SDA is never pulled low, and no strobe is raised for any further byte until the next start.
- R4: In a write, the first two bytes after the address form the subaddress, high byte first, presented on `sub_addr_o` with a one-clock `sub_ld_o` pulse after the second byte.
- R5: Every byte after the subaddress in a write pulses `wr_stb_o` with the byte on `wr_data_o`, and every write byte is acknowledged.
- R6: In a read, a `rd_stb_o` pulse requests a byte, which is sampled from `rd_data_i` on the next clock and driven onto SDA MSB first.
- R7: A master ACK (SDA low on the ninth clock) after a read byte raises one more `rd_stb_o`; a NACK releases the bus with no further strobe.
- R8: A repeated start discards the current byte position and runs the address phase again without loading a subaddress, so the register engine keeps its position for the read that follows.
- R9: The block changes its SDA drive only while the synchronized SCL is low.
- R10: Synchronous active-high reset leaves SDA released and every strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as sampled from the bus |
| sda_i | input | 1 | Serial data line as sampled from the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a1_i | input | 1 | Strap for device address bit 1 |
| strap_a0_i | input | 1 | Strap for device address bit 0 |
| sub_ld_o | output | 1 | One-clock pulse: new subaddress valid |
| sub_addr_o | output | 16 | Register subaddress collected from a write |
| wr_stb_o | output | 1 | One-clock pulse: write data byte valid |
| wr_data_o | output | 8 | Data byte received from the master |
| rd_stb_o | output | 1 | One-clock pulse: request for the next read byte |
| rd_data_i | input | 8 | Read byte from the register engine, valid the clock after `rd_stb_o` |
| xfer_end_o | output | 1 | One-clock pulse when a stop condition ends the transfer |

## Verification
The bound checker watches four things on every clock:

- SDA drive changes only while the synchronized SCL is low, apart from the release forced by a start or stop.
- A start or a stop always releases the bus, and a stop raises the end pulse.
- The three register strobes never overlap.
- Read strobes come only in read mode, and write-side strobes never do.

Only the bench's transactions can show the rest:

- address matching against the straps, with the acknowledge seen on the ninth clock;
- the ordering of the subaddress bytes;
- the bit order of read data;
- the ACK and NACK handling of a read burst;
- a subaddress kept across a repeated start, shown by reading back written bytes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Bus-side phase of the transfer
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } st_e;

  // Meaning of the byte currently being received
  typedef enum logic [1:0] {
    BY_ADDR,
    BY_SUBH,
    BY_SUBL,
    BY_DATA
  } role_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int             W      = 2,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      q_prev_o <= RST_VAL;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      q_prev_o <= pipe[STAGES-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic scl_i,
  input  logic scl_q_i,
  input  logic sda_i,
  input  logic sda_q_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // SCL held high across the SDA transition
  logic scl_held;
  assign scl_held = scl_i & scl_q_i;
  assign start_o  = scl_held & sda_q_i & ~sda_i;
  assign stop_o   = scl_held & ~sda_q_i & sda_i;
  assign rise_o   = scl_i & ~scl_q_i;
  assign fall_o   = ~scl_i & scl_q_i;
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2cs_pkg::*;
#(
  parameter int          BYTE_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [4:0]  DEV_ADDR_HI = 5'b01110
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic                strap_a1_i,
  input  logic                strap_a0_i,
  output logic                sub_ld_o,
  output logic [2*BYTE_W-1:0] sub_addr_o,
  output logic                wr_stb_o,
  output logic [BYTE_W-1:0]   wr_data_o,
  output logic                rd_stb_o,
  input  logic [BYTE_W-1:0]   rd_data_i,
  output logic                xfer_end_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_q, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .d_i      ({scl_i, sda_i}),
    .q_o      ({scl_s, sda_s}),
    .q_prev_o ({scl_q, sda_q})
  );

  i2cs_cond cond_i (
    .scl_i   (scl_s),
    .scl_q_i (scl_q),
    .sda_i   (sda_s),
    .sda_q_i (sda_q),
    .start_o (start_det),
    .stop_o  (stop_det),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall)
  );

  st_e               st;
  role_e             role;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] sub_hi;
  logic              rd_mode;
  logic              mst_ack;
  logic [6:0]        dev_addr;

  assign dev_addr = {DEV_ADDR_HI, strap_a1_i, strap_a0_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      role       <= BY_ADDR;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      sub_hi     <= '0;
      rd_mode    <= 1'b0;
      mst_ack    <= 1'b0;
      sda_oe_o   <= 1'b0;
      sub_ld_o   <= 1'b0;
      sub_addr_o <= '0;
      wr_stb_o   <= 1'b0;
      wr_data_o  <= '0;
      rd_stb_o   <= 1'b0;
      xfer_end_o <= 1'b0;
    end else begin
      sub_ld_o   <= 1'b0;
      wr_stb_o   <= 1'b0;
      rd_stb_o   <= 1'b0;
      xfer_end_o <= 1'b0;
      // read byte is valid the clock after its request
      if (rd_stb_o) tx_sh <= rd_data_i;

      if (stop_det) begin
        st         <= ST_IDLE;
        sda_oe_o   <= 1'b0;
        xfer_end_o <= 1'b1;
      end else if (start_det) begin
        st       <= ST_RX;
        role     <= BY_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              cnt <= '0;
              if (role == BY_ADDR) begin
                if (rx_sh[BYTE_W-1:1] == dev_addr) begin
                  sda_oe_o <= 1'b1;
                  st       <= ST_RX_ACK;
                  rd_mode  <= rx_sh[0];
                  if (rx_sh[0]) rd_stb_o <= 1'b1;
                  else          role     <= BY_SUBH;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                st       <= ST_RX_ACK;
                case (role)
                  BY_SUBH: begin
                    sub_hi <= rx_sh;
                    role   <= BY_SUBL;
                  end
                  BY_SUBL: begin
                    sub_ld_o   <= 1'b1;
                    sub_addr_o <= {sub_hi, rx_sh};
                    role       <= BY_DATA;
                  end
                  default: begin
                    wr_stb_o  <= 1'b1;
                    wr_data_o <= rx_sh;
                  end
                endcase
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                st       <= ST_TX;
                sda_oe_o <= ~tx_sh[BYTE_W-1];
              end else begin
                st       <= ST_RX;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe_o <= 1'b0;
                mst_ack  <= 1'b0;
                st       <= ST_TX_ACK;
              end else begin
                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                mst_ack  <= 1'b1;
                rd_stb_o <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end else if (scl_fall && mst_ack) begin
              st       <= ST_TX;
              cnt      <= '0;
              sda_oe_o <= ~tx_sh[BYTE_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic sub_ld,
  input logic wr_stb,
  input logic rd_stb,
  input logic rd_mode,
  input logic xfer_end
);
  timeunit 1ns;
  timeprecision 1ps;

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (xfer_end && !sda_oe));

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sub_ld, wr_stb, rd_stb}));

  // R6
  rd_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> rd_mode);

  // R5
  wr_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || sub_ld) |-> !rd_mode);
endmodule

bind i2c_regport_slave i2cs_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe_o),
  .sub_ld    (sub_ld_o),
  .wr_stb    (wr_stb_o),
  .rd_stb    (rd_stb_o),
  .rd_mode   (rd_mode),
  .xfer_end  (xfer_end_o)
);

// File: tb/i2c_regport_slave_tb_top.sv
module i2c_regport_slave_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int H = 20;  // clocks per SCL half period

  // {subaddress[15:0], data[7:0]}
  localparam logic [23:0] VEC [6] = '{
    24'h0000A5, 24'h00013C, 24'h1207F0,
    24'h400E0F, 24'hFFFF81, 24'h00096E
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        a1 = 1'b0, a0 = 1'b0;
  logic        sda_oe;
  logic        sub_ld, wr_stb, rd_stb, xfer_end;
  logic [15:0] sub_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data = 8'h00;
  logic        sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regport_slave dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .strap_a1_i (a1),
    .strap_a0_i (a0),
    .sub_ld_o   (sub_ld),
    .sub_addr_o (sub_addr),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .rd_stb_o   (rd_stb),
    .rd_data_i  (rd_data),
    .xfer_end_o (xfer_end)
  );

  // Register engine model
  logic [7:0]  mem [16];
  logic [3:0]  ptr = 4'h0;
  int          sub_n = 0, wr_n = 0, rd_n = 0, end_n = 0;
  logic [15:0] last_sub = 16'h0;
  logic [7:0]  last_wr = 8'h0;

  always @(negedge clk) begin
    if (sub_ld) begin
      ptr <= sub_addr[3:0]; last_sub <= sub_addr; sub_n <= sub_n + 1;
    end
    if (wr_stb) begin
      mem[ptr] <= wr_data; last_wr <= wr_data; ptr <= ptr + 4'd1; wr_n <= wr_n + 1;
    end
    if (rd_stb) begin
      rd_data <= mem[ptr]; ptr <= ptr + 4'd1; rd_n <= rd_n + 1;
    end
    if (xfer_end) end_n <= end_n + 1;
  end

  // R9 monitor: drive changes while SCL stays high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  int   viol = 0;
  always @(negedge clk) begin
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
    if (!rst && scl_m && prev_scl && (sda_oe != prev_oe)) viol <= viol + 1;
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H);
    sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(H);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2);
    ack = ~sda_bus; hw(H/2); scl_m = 1'b0;
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2);
      b[i] = sda_bus; hw(H/2); scl_m = 1'b0;
    end
    sda_m = ~give_ack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] b;
    int         s0, w0, r0, e0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    hw(4);
    // R10: reset state
    chk("R10 oe", {31'd0, sda_oe}, 32'd0);
    chk("R10 strobes", {28'd0, sub_ld, wr_stb, rd_stb, xfer_end}, 32'd0);

    // Vector table: single write, then read back through repeated start
    for (int v = 0; v < 6; v++) begin
      e0 = end_n;
      m_start();
      m_wbyte(8'h70, ack);               chk("R2 ack write addr", {31'd0, ack}, 32'd1);
      m_wbyte(VEC[v][23:16], ack);
      m_wbyte(VEC[v][15:8], ack);        chk("R4 ack sub", {31'd0, ack}, 32'd1);
      m_wbyte(VEC[v][7:0], ack);         chk("R5 ack data", {31'd0, ack}, 32'd1);
      m_stop(); hw(4);
      chk("R4 subaddress", {16'd0, last_sub}, {16'd0, VEC[v][23:8]});
      chk("R5 write data", {24'd0, last_wr}, {24'd0, VEC[v][7:0]});
      chk("R1 stop pulse", end_n, e0 + 1);

      m_start();
      m_wbyte(8'h70, ack);
      m_wbyte(VEC[v][23:16], ack);
      m_wbyte(VEC[v][15:8], ack);
      s0 = sub_n;
      m_start();
      m_wbyte(8'h71, ack);               chk("R2 ack read addr", {31'd0, ack}, 32'd1);
      m_rbyte(1'b0, b);                  chk("R6 read data", {24'd0, b}, {24'd0, VEC[v][7:0]});
      m_stop(); hw(4);
      chk("R8 no subaddress load on repeated start", sub_n, s0);
    end

    // R3: address mismatches with straps 00
    s0 = sub_n; w0 = wr_n; r0 = rd_n;
    m_start();
    m_wbyte(8'h74, ack);                 chk("R3 nack strap a1", {31'd0, ack}, 32'd0);
    m_wbyte(8'h00, ack);                 chk("R3 nack later byte", {31'd0, ack}, 32'd0);
    m_wbyte(8'h05, ack);
    m_wbyte(8'h99, ack);
    m_stop();
    m_start();
    m_wbyte(8'h30, ack);                 chk("R3 nack fixed bits", {31'd0, ack}, 32'd0);
    m_stop();
    m_start();
    m_wbyte(8'h73, ack);                 chk("R3 nack strap a0 read", {31'd0, ack}, 32'd0);
    m_stop(); hw(4);
    chk("R3 no strobes", sub_n + wr_n + rd_n, s0 + w0 + r0);

    // R2: strap pins select the address (a1=1, a0=0 -> byte 0x74)
    a1 = 1'b1;
    m_start();
    m_wbyte(8'h74, ack);                 chk("R2 strap match", {31'd0, ack}, 32'd1);
    m_wbyte(8'h00, ack);
    m_wbyte(8'h02, ack);
    m_wbyte(8'h77, ack);
    m_stop(); hw(4);
    chk("R2 strap write data", {24'd0, last_wr}, 32'h77);
    m_start();
    m_wbyte(8'h70, ack);                 chk("R2 old address refused", {31'd0, ack}, 32'd0);
    m_stop();
    a1 = 1'b0;

    // R5/R7: burst write of three bytes, burst read with ACK, ACK, NACK
    w0 = wr_n;
    m_start();
    m_wbyte(8'h70, ack);
    m_wbyte(8'h00, ack);
    m_wbyte(8'h04, ack);
    m_wbyte(8'h11, ack);
    m_wbyte(8'h22, ack);
    m_wbyte(8'h33, ack);                 chk("R5 ack burst byte", {31'd0, ack}, 32'd1);
    m_stop(); hw(4);
    chk("R5 burst write count", wr_n, w0 + 3);

    m_start();
    m_wbyte(8'h70, ack);
    m_wbyte(8'h00, ack);
    m_wbyte(8'h04, ack);
    r0 = rd_n;
    m_start();
    m_wbyte(8'h71, ack);
    m_rbyte(1'b1, b);                    chk("R7 burst byte 0", {24'd0, b}, 32'h11);
    m_rbyte(1'b1, b);                    chk("R7 burst byte 1", {24'd0, b}, 32'h22);
    m_rbyte(1'b0, b);                    chk("R7 burst byte 2", {24'd0, b}, 32'h33);
    hw(6);
    chk("R7 released after nack", {31'd0, sda_oe}, 32'd0);
    m_rbyte(1'b0, b);                    chk("R7 bus idle after nack", {24'd0, b}, 32'hFF);
    m_stop(); hw(4);
    chk("R7 read strobe count", rd_n, r0 + 3);

    // R9: SDA drive never changed while SCL high
    chk("R9 drive change while SCL high", viol, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule